// File: doc/BRIEF.md
# ATA PIO Cycle Timing Engine

This block drives programmed-I/O read and write cycles on a parallel ATA drive bus. The host loads two timing words, a small control word and then one task-file access request at a time. Each request carries an address, a direction and, for writes, the data. The engine runs the cycle in four phases, each timed in host clock counts: address setup, active strobe, hold and recovery. It can also stretch the strobe while the drive holds IORDY low.

Accesses to the 16-bit data register use their own strobe width. All other task-file registers use the 8-bit strobe width and also wait out a minimum recovery time. After reset the timing words hold values for the slowest PIO mode. These values are rounded up from nanosecond limits for the clock period given as a parameter. A request is taken through a ready/valid handshake, and only while the engine is idle. A busy flag reports that a transaction is in progress.

Top module: `pio_strobe_engine`

## Requirements
- R1: After reset the engine is idle (`req_ready`=1, `busy`=0, both strobes high, `drv_data_oe`=0). The timing words hold mode-0 counts: cycle 600 ns, setup 70 ns, 8-bit strobe 290 ns, 16-bit strobe 165 ns, hold 30 ns, IORDY setup 35 ns, recovery 0. Each is divided by `CLK_PERIOD_NS` and rounded up.
- R2: Timing word A (`cfg_sel`=1) holds the cycle time in [31:24], the 8-bit strobe width in [23:16], the 16-bit strobe width in [15:8] and the register recovery in [7:0]. Timing word B (`cfg_sel`=2) holds the hold time in [31:24], the setup time in [23:16] and the IORDY setup in [15:8]. Its bits [7:0] are unused.
- R3: A cycle opens with setup-count clocks in which `drv_addr` shows the request address and neither strobe is low.
- R4: The strobe stays low for the 16-bit width when the address equals `DATA_ADDR`, and for the 8-bit width for any other address. `drv_rd_n` is used for reads and `drv_wr_n` for writes.
- R5: After the strobe rises, the engine holds for hold-count clocks. On writes, `drv_data_oe` is high and `drv_data_out` carries the write data from the first setup clock through the last hold clock.
- R6: `busy` stays high for at least the cycle-time count in total. A non-data access also spends at least the recovery count after hold. There is always at least one recovery clock.
- R7: On reads, `drv_data_in` is captured at the clock edge where the strobe rises. `rsp_valid` pulses for one clock in the first idle cycle, with the captured word on `rsp_rdata`.
- R8: With control bit 24 set, the strobe cannot end until the IORDY-setup count has passed and `drv_iordy` is high, so a low IORDY stretches it. With bit 24 clear, `drv_iordy` has no effect on the strobe.
- R9: While control bit 31 is set, the engine is forced idle from the next clock and aborts any cycle in progress without a `rsp_valid` pulse. `req_ready` stays low until the bit is cleared.
- R10: A timing field of zero acts as a count of one.
- R11: `req_ready` is high only while idle. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for control/timing words |
| cfg_sel | input | 2 | 0 control, 1 timing word A, 2 timing word B |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Engine accepts a request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Task-file register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock pulse when a cycle completes |
| rsp_rdata | output | 16 | Data captured on the last read |
| busy | output | 1 | Transaction in progress |
| drv_addr | output | ADDR_W | Address to the drive |
| drv_rd_n | output | 1 | Read strobe, active low |
| drv_wr_n | output | 1 | Write strobe, active low |
| drv_data_out | output | 16 | Data driven to the drive |
| drv_data_oe | output | 1 | Output enable for drive data |
| drv_data_in | input | 16 | Data from the drive |
| drv_iordy | input | 1 | Drive ready |

## Verification
The assertions assume that the timing words are rewritten only while the engine is idle. They also assume that IORDY, when handling is on, rises within a bounded number of clocks. The bench writes timing words only between cycles and releases IORDY a fixed number of strobe clocks into the stretched phase. The reset bit is the one control change made during a live cycle, because aborting a cycle is exactly what it is for.

// File: rtl/pio_strobe_engine.sv
module pio_strobe_engine #(
  parameter int CLK_PERIOD_NS = 5,
  parameter int ADDR_W        = 4,
  parameter int DATA_ADDR     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] drv_addr,
  output logic              drv_rd_n,
  output logic              drv_wr_n,
  output logic [15:0]       drv_data_out,
  output logic              drv_data_oe,
  input  logic [15:0]       drv_data_in,
  input  logic              drv_iordy
);
  localparam int P = CLK_PERIOD_NS;
  localparam logic [7:0] D_CYC  = 8'((600 + P - 1) / P);
  localparam logic [7:0] D_W8   = 8'((290 + P - 1) / P);
  localparam logic [7:0] D_W16  = 8'((165 + P - 1) / P);
  localparam logic [7:0] D_HOLD = 8'((30 + P - 1) / P);
  localparam logic [7:0] D_SET  = 8'((70 + P - 1) / P);
  localparam logic [7:0] D_RDY  = 8'((35 + P - 1) / P);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_RECOV} st_t;

  st_t st;
  logic ctl_rst, ctl_rdy;
  logic [31:0] tim_a, tim_b;
  logic [7:0] cnt, tot;
  logic is_wr, is_data, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0] wdata_q, rdata_q;

  function automatic logic [7:0] nz(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction

  wire [7:0] t_cyc  = nz(tim_a[31:24]);
  wire [7:0] t_w8   = nz(tim_a[23:16]);
  wire [7:0] t_w16  = nz(tim_a[15:8]);
  wire [7:0] t_rec  = nz(tim_a[7:0]);
  wire [7:0] t_hold = nz(tim_b[31:24]);
  wire [7:0] t_set  = nz(tim_b[23:16]);
  wire [7:0] t_rdy  = nz(tim_b[15:8]);

  wire [7:0] t_width   = is_data ? t_w16 : t_w8;
  wire [7:0] cnt_inc   = (cnt == 8'hFF) ? cnt : cnt + 8'd1;
  wire [7:0] tot_inc   = (tot == 8'hFF) ? tot : tot + 8'd1;
  wire strobe_end      = (cnt >= t_width) && (!ctl_rdy || ((cnt >= t_rdy) && drv_iordy));
  wire recov_end       = (tot >= t_cyc) && (is_data || (cnt >= t_rec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_rst <= 1'b0;
      ctl_rdy <= 1'b0;
      tim_a   <= {D_CYC, D_W8, D_W16, 8'd0};
      tim_b   <= {D_HOLD, D_SET, D_RDY, 8'd0};
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: begin ctl_rst <= cfg_wdata[31]; ctl_rdy <= cfg_wdata[24]; end
        2'd1: tim_a <= cfg_wdata;
        2'd2: tim_b <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tot <= '0; done_q <= 1'b0;
      is_wr <= 1'b0; is_data <= 1'b0; addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
    end else if (ctl_rst) begin
      st <= S_IDLE; done_q <= 1'b0;
    end else begin
      if (st != S_IDLE) tot <= tot_inc;
      case (st)
        S_IDLE: begin
          done_q <= 1'b0;
          if (req_valid) begin
            st <= S_SETUP; cnt <= 8'd1; tot <= 8'd1;
            is_wr <= req_write; addr_q <= req_addr; wdata_q <= req_wdata;
            is_data <= (req_addr == ADDR_W'(DATA_ADDR));
          end
        end
        S_SETUP:  if (cnt >= t_set) begin st <= S_STROBE; cnt <= 8'd1; end else cnt <= cnt_inc;
        S_STROBE: if (strobe_end) begin
                    st <= S_HOLD; cnt <= 8'd1;
                    if (!is_wr) rdata_q <= drv_data_in;
                  end else cnt <= cnt_inc;
        S_HOLD:   if (cnt >= t_hold) begin st <= S_RECOV; cnt <= 8'd1; end else cnt <= cnt_inc;
        S_RECOV:  if (recov_end) begin st <= S_IDLE; done_q <= 1'b1; end else cnt <= cnt_inc;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == S_IDLE) && !ctl_rst;
  assign busy         = (st != S_IDLE);
  assign drv_addr     = addr_q;
  assign drv_rd_n     = !((st == S_STROBE) && !is_wr);
  assign drv_wr_n     = !((st == S_STROBE) && is_wr);
  assign drv_data_out = wdata_q;
  assign drv_data_oe  = is_wr && (st == S_SETUP || st == S_STROBE || st == S_HOLD);
  assign rsp_valid    = done_q;
  assign rsp_rdata    = rdata_q;

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!drv_rd_n && !drv_wr_n));
  assert_ready_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  assert_reset_bit_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> (!busy && !rsp_valid));
  assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (drv_rd_n && drv_wr_n));
  assert_oe_not_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_data_oe |-> drv_rd_n);
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $fell(busy));
endmodule

// File: tb/pio_strobe_engine_tb.sv
module pio_strobe_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0; logic [3:0] req_addr = 0; logic [15:0] req_wdata = 0;
  logic req_ready, rsp_valid, busy, drv_rd_n, drv_wr_n, drv_data_oe;
  logic [15:0] rsp_rdata, drv_data_out; logic [3:0] drv_addr;
  logic [15:0] drv_data_in = 0; logic drv_iordy = 1'b1;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pio_strobe_engine #(.CLK_PERIOD_NS(5), .ADDR_W(4), .DATA_ADDR(0)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .req_valid, .req_ready, .req_write,
    .req_addr, .req_wdata, .rsp_valid, .rsp_rdata, .busy, .drv_addr, .drv_rd_n,
    .drv_wr_n, .drv_data_out, .drv_data_oe, .drv_data_in, .drv_iordy);

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  int o_busy, o_set, o_str, o_hold, o_bad, o_rv, o_rd;
  task automatic run(input bit wr, input logic [3:0] a, input logic [15:0] d,
                     input logic [15:0] din, input int rel_at);
    bit seen = 0, post = 0;
    o_busy = 0; o_set = 0; o_str = 0; o_hold = 0; o_bad = 0;
    drv_data_in = din;
    @(negedge clk); req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0;
    while (busy && o_busy < 2000) begin
      o_busy++;
      if (req_ready || drv_addr != a) o_bad++;
      if (wr ? !drv_wr_n : !drv_rd_n) begin
        o_str++; seen = 1;
        if (rel_at >= 0 && o_str == rel_at) drv_iordy = 1;
      end else if (!seen) begin
        o_set++;
        if (drv_data_oe != wr || (wr && drv_data_out != d)) o_bad++;
      end else begin
        if (!post) begin post = 1; drv_data_in = ~din; end
        if (drv_data_oe) o_hold++;
      end
      @(negedge clk);
    end
    o_rv = rsp_valid; o_rd = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready, 1); chk("R1 busy", busy, 0);
    chk("R1 strobes", {drv_rd_n, drv_wr_n}, 3); chk("R1 oe", drv_data_oe, 0);
    run(0, 4'd0, 0, 16'h1234, -1);
    chk("R1 default setup", o_set, 14); chk("R1 default w16", o_str, 33);
    chk("R1 default cycle", o_busy, 120);
    run(0, 4'd1, 0, 16'h0055, -1);
    chk("R1 default w8", o_str, 58); chk("R1 default reg cycle", o_busy, 120);
  endtask

  task automatic t_programmed;
    cfg(1, {8'd20, 8'd9, 8'd4, 8'd12}); cfg(2, {8'd3, 8'd2, 8'd1, 8'd0});
    run(1, 4'd0, 16'hBEEF, 0, -1);
    chk("R3 setup", o_set, 2); chk("R4 data strobe", o_str, 4);
    chk("R5 hold oe", o_hold, 3); chk("R6 data cycle", o_busy, 20);
    chk("R11 ready/addr/oe during cycle", o_bad, 0); chk("R2 write done", o_rv, 1);
    run(1, 4'd5, 16'h00A7, 0, -1);
    chk("R4 reg strobe", o_str, 9); chk("R6 reg recovery", o_busy, 26);
    run(0, 4'd0, 0, 16'hA5C3, -1);
    chk("R7 rsp_valid", o_rv, 1); chk("R7 capture", o_rd, 16'hA5C3);
    chk("R2 read cycle", o_busy, 20);
    @(negedge clk); chk("R7 pulse width", rsp_valid, 0);
  endtask

  task automatic t_zero;
    cfg(1, 0); cfg(2, 0);
    run(0, 4'd0, 0, 16'h0F0F, -1);
    chk("R10 setup", o_set, 1); chk("R10 strobe", o_str, 1); chk("R10 cycle", o_busy, 4);
    run(0, 4'd3, 0, 16'h0F0F, -1);
    chk("R10 reg cycle", o_busy, 4);
  endtask

  task automatic t_iordy;
    cfg(1, {8'd20, 8'd9, 8'd4, 8'd12}); cfg(2, {8'd3, 8'd2, 8'd1, 8'd0});
    cfg(0, 32'h0100_0000);
    drv_iordy = 0; run(0, 4'd0, 0, 16'h7777, 10);
    chk("R8 stretched strobe", o_str, 10); chk("R8 stretched cycle", o_busy, 20);
    chk("R8 capture", o_rd, 16'h7777);
    cfg(0, 32'h0); drv_iordy = 0; run(0, 4'd0, 0, 16'h1111, -1);
    chk("R8 ignored when off", o_str, 4);
    drv_iordy = 1;
  endtask

  task automatic t_abort;
    int rv_seen = 0;
    cfg(1, {8'd200, 8'd100, 8'd100, 8'd0}); cfg(2, {8'd3, 8'd2, 8'd1, 8'd0});
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = 0; req_wdata = 16'h1;
    @(negedge clk); req_valid = 0;
    repeat (6) @(negedge clk);
    chk("R9 strobe active before abort", drv_wr_n, 0);
    cfg(0, 32'h8000_0000);
    repeat (3) begin rv_seen += rsp_valid; @(negedge clk); end
    chk("R9 aborted busy", busy, 0); chk("R9 strobe released", drv_wr_n, 1);
    chk("R9 ready held low", req_ready, 0); chk("R9 no completion", rv_seen, 0);
    cfg(0, 32'h0);
    chk("R9 ready after clear", req_ready, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_programmed(); t_zero(); t_iordy(); t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule